// File: doc/BRIEF.md
# Affine Background Parameter Register Bank

This block holds the control state of a rotation/scaling background layer. A CPU on an 8-bit bus loads six signed 16-bit transform parameters (matrix terms A, B, C, D and the rotation centre X, Y) and two signed 16-bit scroll offsets. Every 16-bit value arrives as two byte writes, low byte first. A single byte latch, shared by all eight 16-bit registers, holds the previous byte. An 8-bit mode register is loaded directly. The assembled values drive a downstream renderer through plain output ports.

The same register writes feed a small signed multiplier. It multiplies the full 16-bit A term by the raw byte most recently written to the B address. The CPU reads the 24-bit product back as three bytes. Reads are answered one cycle after the read strobe, with a valid flag. If a write and a read happen in the same cycle, the read sees the state after the write.

Top module: `affine_param_regs`

## Requirements
- R1: Any write to one of the eight 16-bit targets sets that target to {write byte, shared latch} (write byte in bits 15:8), then loads the write byte into the shared latch.
- R2: Write addresses 0x211B, 0x211C, 0x211D, 0x211E, 0x211F and 0x2120 select parameters A, B, C, D, centre X and centre Y respectively.
- R3: A write to 0x211A loads the 8-bit mode register with the write byte and leaves the shared latch unchanged.
- R4: Writes to 0x210D and 0x210E assemble the horizontal and vertical scroll offsets using the same shared latch as R1.
- R5: The multiplier operand is the raw signed byte of the most recent write to 0x211C, not the assembled B register.
- R6: The product is signed A (16 bits) times the signed operand of R5, sign-extended to 24 bits. Read addresses 0x2134, 0x2135 and 0x2136 return bits 7:0, 15:8 and 23:16.
- R7: Reset (active-low rst_n) clears every parameter, offset, mode register, operand and the shared latch to zero.
- R8: A read strobe at a clock edge gives rd_valid and rd_data after that edge, for one cycle. A read to any address other than the three product bytes gives rd_valid low and rd_data zero.
- R9: A write to an unmapped address (for example 0x2121) changes no register, including the shared latch.
- R10: When write and read strobes occur in the same cycle, the read returns the product computed from the values after that write.
- R11: Reads have no side effects. The shared latch and all registers are unchanged by them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 16 | Write byte address |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 16 | Read byte address |
| rd_data | output | 8 | Read byte, registered |
| rd_valid | output | 1 | Read answered with a product byte |
| mode_bits | output | 8 | Mode-settings register |
| par_a | output | 16 | Parameter A |
| par_b | output | 16 | Parameter B |
| par_c | output | 16 | Parameter C |
| par_d | output | 16 | Parameter D |
| ctr_x | output | 16 | Rotation centre X |
| ctr_y | output | 16 | Rotation centre Y |
| hscroll | output | 16 | Horizontal scroll offset |
| vscroll | output | 16 | Vertical scroll offset |

## Verification
Register outputs change at the edge that captures a write. The bench samples them at the falling edge straight after that write. A product byte is due exactly one edge after its read strobe. The driver pushes the expected byte and valid flag when it raises the strobe. The monitor records which edges carried a read and pops the queue at the falling edge that follows, so every answer is compared in its own cycle. Cycles with no read must show rd_valid low.

// File: rtl/affine_regs_pkg.sv
package affine_regs_pkg;
  localparam int DATA_W   = 8;
  localparam int REG_W    = 2 * DATA_W;
  localparam int PROD_W   = REG_W + DATA_W;
  localparam int NUM_PAR  = 6;
  localparam int NUM_SLOT = NUM_PAR + 2;
  localparam int PROD_BYTES = PROD_W / DATA_W;

  // slot numbering of the eight latched 16-bit targets
  localparam int SLOT_A    = 0;
  localparam int SLOT_B    = 1;
  localparam int SLOT_HSCR = NUM_PAR;
  localparam int SLOT_VSCR = NUM_PAR + 1;

  // new byte goes on top, the held byte underneath
  function automatic logic [REG_W-1:0] join_bytes(input logic [DATA_W-1:0] hi,
                                                  input logic [DATA_W-1:0] lo);
    return {hi, lo};
  endfunction

  // signed 16 x signed 8, both sign-extended to the product width
  function automatic logic [PROD_W-1:0] smul(input logic [REG_W-1:0] a,
                                             input logic [DATA_W-1:0] b);
    logic signed [PROD_W-1:0] ea;
    logic signed [PROD_W-1:0] eb;
    ea = $signed({{(PROD_W-REG_W){a[REG_W-1]}}, a});
    eb = $signed({{(PROD_W-DATA_W){b[DATA_W-1]}}, b});
    return PROD_W'(ea * eb);
  endfunction
endpackage

// File: rtl/affine_wr_decode.sv
module affine_wr_decode
  import affine_regs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 16'h211A,
  parameter logic [ADDR_W-1:0] PAR_BASE  = 16'h211B,
  parameter logic [ADDR_W-1:0] HSCR_ADDR = 16'h210D,
  parameter logic [ADDR_W-1:0] VSCR_ADDR = 16'h210E
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  output logic [NUM_SLOT-1:0] slot_hit,
  output logic                mode_hit
);
  for (genvar i = 0; i < NUM_PAR; i++) begin : g_par
    assign slot_hit[i] = wr_en && (wr_addr == ADDR_W'(PAR_BASE + ADDR_W'(i)));
  end
  assign slot_hit[SLOT_HSCR] = wr_en && (wr_addr == HSCR_ADDR);
  assign slot_hit[SLOT_VSCR] = wr_en && (wr_addr == VSCR_ADDR);
  assign mode_hit            = wr_en && (wr_addr == MODE_ADDR);

  // R2: a write selects at most one target
  p_one_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({slot_hit, mode_hit}));
  // R2: no hit without a strobe
  p_hit_needs_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|{slot_hit, mode_hit}) |-> wr_en);
endmodule

// File: rtl/affine_latch_bank.sv
module affine_latch_bank
  import affine_regs_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_SLOT-1:0]            slot_hit,
  input  logic                           mode_hit,
  input  logic [DATA_W-1:0]              wr_data,
  output logic [NUM_SLOT-1:0][REG_W-1:0] slot_q,
  output logic [DATA_W-1:0]              mode_q,
  output logic [REG_W-1:0]               a_next,
  output logic [DATA_W-1:0]              b8_next
);
  logic [DATA_W-1:0] latch_q;
  logic [DATA_W-1:0] b8_q;
  logic              any_slot;
  logic              b_write;
  logic [NUM_SLOT-1:0][REG_W-1:0] slot_d;

  assign any_slot = |slot_hit;
  assign b_write  = slot_hit[SLOT_B];

  for (genvar i = 0; i < NUM_SLOT; i++) begin : g_slot
    assign slot_d[i] = slot_hit[i] ? join_bytes(wr_data, latch_q) : slot_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[i] <= '0;
      else        slot_q[i] <= slot_d[i];
    end

    // R1: the target takes the new byte over the byte held before the write
    p_join_r1: assert property (@(posedge clk) disable iff (!rst_n)
      slot_hit[i] |=> slot_q[i] == {$past(wr_data), $past(latch_q)});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      b8_q    <= '0;
      mode_q  <= '0;
    end else begin
      if (any_slot) latch_q <= wr_data;
      if (b_write)  b8_q    <= wr_data;
      if (mode_hit) mode_q  <= wr_data;
    end
  end

  // values as they stand after this cycle's write, for same-cycle reads
  assign a_next  = slot_d[SLOT_A];
  assign b8_next = b_write ? wr_data : b8_q;

  p_latch_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    any_slot |=> latch_q == $past(wr_data));
  p_mode_direct_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_hit |=> (mode_q == $past(wr_data)) && $stable(latch_q));
  p_raw_operand_r5: assert property (@(posedge clk) disable iff (!rst_n)
    b_write |=> b8_q == $past(wr_data));
  p_unmapped_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(any_slot || mode_hit) |=> $stable(latch_q) && $stable(slot_q) && $stable(mode_q));
  p_reset_zero_r7: assert property (@(posedge clk)
    !rst_n |-> (latch_q == '0) && (b8_q == '0) && (mode_q == '0) && (slot_q == '0));
endmodule

// File: rtl/affine_prod_read.sv
module affine_prod_read
  import affine_regs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PROD_BASE = 16'h2134
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic [REG_W-1:0]   a_next,
  input  logic [DATA_W-1:0]  b8_next,
  output logic [DATA_W-1:0]  rd_data,
  output logic               rd_valid
);
  logic [PROD_BYTES-1:0] byte_sel;
  logic [PROD_W-1:0]     product;
  logic [DATA_W-1:0]     byte_mux;
  logic                  rd_hit;

  assign product = smul(a_next, b8_next);

  for (genvar k = 0; k < PROD_BYTES; k++) begin : g_sel
    assign byte_sel[k] = rd_en && (rd_addr == ADDR_W'(PROD_BASE + ADDR_W'(k)));
  end
  assign rd_hit = |byte_sel;

  always_comb begin
    byte_mux = '0;
    for (int k = 0; k < PROD_BYTES; k++)
      if (byte_sel[k]) byte_mux = product[k*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_hit;
      rd_data  <= rd_hit ? byte_mux : '0;
    end
  end

  // R8: an answer only follows a read strobe, and only lasts one cycle without one
  p_valid_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en));
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> rd_data == '0);
  p_one_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(byte_sel));
endmodule

// File: rtl/affine_param_regs.sv
module affine_param_regs
  import affine_regs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 16'h211A,
  parameter logic [ADDR_W-1:0] PAR_BASE  = 16'h211B,
  parameter logic [ADDR_W-1:0] HSCR_ADDR = 16'h210D,
  parameter logic [ADDR_W-1:0] VSCR_ADDR = 16'h210E,
  parameter logic [ADDR_W-1:0] PROD_BASE = 16'h2134
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic [7:0]        mode_bits,
  output logic [15:0]       par_a,
  output logic [15:0]       par_b,
  output logic [15:0]       par_c,
  output logic [15:0]       par_d,
  output logic [15:0]       ctr_x,
  output logic [15:0]       ctr_y,
  output logic [15:0]       hscroll,
  output logic [15:0]       vscroll
);
  logic [NUM_SLOT-1:0]            slot_hit;
  logic                           mode_hit;
  logic [NUM_SLOT-1:0][REG_W-1:0] slot_q;
  logic [REG_W-1:0]               a_next;
  logic [DATA_W-1:0]              b8_next;

  affine_wr_decode #(
    .ADDR_W(ADDR_W), .MODE_ADDR(MODE_ADDR), .PAR_BASE(PAR_BASE),
    .HSCR_ADDR(HSCR_ADDR), .VSCR_ADDR(VSCR_ADDR)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .slot_hit(slot_hit), .mode_hit(mode_hit)
  );

  affine_latch_bank u_bank (
    .clk(clk), .rst_n(rst_n), .slot_hit(slot_hit), .mode_hit(mode_hit),
    .wr_data(wr_data), .slot_q(slot_q), .mode_q(mode_bits),
    .a_next(a_next), .b8_next(b8_next)
  );

  affine_prod_read #(.ADDR_W(ADDR_W), .PROD_BASE(PROD_BASE)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .a_next(a_next), .b8_next(b8_next), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  assign par_a   = slot_q[0];
  assign par_b   = slot_q[1];
  assign par_c   = slot_q[2];
  assign par_d   = slot_q[3];
  assign ctr_x   = slot_q[4];
  assign ctr_y   = slot_q[5];
  assign hscroll = slot_q[SLOT_HSCR];
  assign vscroll = slot_q[SLOT_VSCR];

  // R11: a read alone leaves every register as it was
  p_read_no_effect_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en) |=> $stable(slot_q) && $stable(mode_bits));
endmodule

// File: tb/sim_affine_param_regs.sv
module sim_affine_param_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_addr = '0;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic [7:0]  mode_bits;
  logic [15:0] par_a, par_b, par_c, par_d, ctr_x, ctr_y, hscroll, vscroll;

  int compared = 0;
  int mismatched = 0;
  bit rd_fire = 1'b0;

  logic [8:0] exp_q[$];
  string      tag_q[$];

  // bench-side model
  logic [7:0]  m_latch = '0;
  logic [7:0]  m_mode  = '0;
  logic [7:0]  m_op    = '0;
  logic [15:0] m_reg[8];

  always #(CLK_PERIOD/2) clk = ~clk;

  affine_param_regs u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .mode_bits(mode_bits), .par_a(par_a), .par_b(par_b), .par_c(par_c), .par_d(par_d),
    .ctr_x(ctr_x), .ctr_y(ctr_y), .hscroll(hscroll), .vscroll(vscroll)
  );

  function automatic int slot_of(input logic [15:0] a);
    if (a >= 16'h211B && a <= 16'h2120) return int'(a - 16'h211B);
    if (a == 16'h210D) return 6;
    if (a == 16'h210E) return 7;
    return -1;
  endfunction

  task automatic model_write(input logic [15:0] a, input logic [7:0] d);
    int s;
    s = slot_of(a);
    if (a == 16'h211A) m_mode = d;
    else if (s >= 0) begin
      m_reg[s] = (16'(d) << 8) + 16'(m_latch);
      m_latch = d;
      if (s == 1) m_op = d;
    end
  endtask

  function automatic logic [8:0] model_read(input logic [15:0] a);
    longint pa, pb, p;
    if (a < 16'h2134 || a > 16'h2136) return 9'h000;
    pa = longint'(m_reg[0]);
    if (pa >= 32768) pa = pa - 65536;
    pb = longint'(m_op);
    if (pb >= 128) pb = pb - 256;
    p = pa * pb;
    if (p < 0) p = p + 64'd16777216;
    return {1'b1, 8'((p >> (8 * int'(a - 16'h2134))) & 255)};
  endfunction

  task automatic chk(input string req, input string what, input logic [15:0] act,
                     input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    chk(req, "par_a", par_a, m_reg[0]);
    chk(req, "par_b", par_b, m_reg[1]);
    chk(req, "par_c", par_c, m_reg[2]);
    chk(req, "par_d", par_d, m_reg[3]);
    chk(req, "ctr_x", ctr_x, m_reg[4]);
    chk(req, "ctr_y", ctr_y, m_reg[5]);
    chk(req, "hscroll", hscroll, m_reg[6]);
    chk(req, "vscroll", vscroll, m_reg[7]);
    chk(req, "mode_bits", {8'h00, mode_bits}, {8'h00, m_mode});
  endtask

  // one cycle: drive just after a falling edge, return at the next falling edge
  task automatic op(input bit w, input logic [15:0] wa, input logic [7:0] wd,
                    input bit r, input logic [15:0] ra, input string req);
    wr_en = w; wr_addr = wa; wr_data = wd;
    rd_en = r; rd_addr = ra;
    if (w) model_write(wa, wd);
    if (r) begin exp_q.push_back(model_read(ra)); tag_q.push_back(req); end
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input string req);
    op(1'b1, a, d, 1'b0, 16'h0000, req);
  endtask

  task automatic rd(input logic [15:0] a, input string req);
    op(1'b0, 16'h0000, 8'h00, 1'b1, a, req);
  endtask

  task automatic rd_prod(input string req);
    rd(16'h2134, req); rd(16'h2135, req); rd(16'h2136, req);
  endtask

  // monitor: a read strobe seen at a rising edge is answered by the next falling edge
  always @(posedge clk) rd_fire <= rd_en;
  always @(negedge clk) begin
    if (rd_fire) begin
      if (exp_q.size() == 0) begin
        compared++; mismatched++;
        $display("FAIL R8 unexpected read: actual %b/%h expected none", rd_valid, rd_data);
      end else begin
        logic [8:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        compared++;
        if ({rd_valid, rd_data} !== e) begin
          mismatched++;
          $display("FAIL %s read: actual %b/%h expected %b/%h", t, rd_valid, rd_data, e[8], e[7:0]);
        end
      end
    end else if (rst_n && rd_valid !== 1'b0) begin
      compared++; mismatched++;
      $display("FAIL R8 valid without read: actual %b expected 0", rd_valid);
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    repeat (3) @(negedge clk);
    // R7: reset state
    check_regs("R7");
    chk("R7", "rd_valid", {15'h0, rd_valid}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    rd_prod("R7");

    // R1 R2: two-byte assembly of A and B
    wr(16'h211B, 8'h34, "R1"); check_regs("R1");
    wr(16'h211B, 8'h12, "R1"); check_regs("R1");
    wr(16'h211C, 8'hFE, "R2"); wr(16'h211C, 8'hFF, "R2"); check_regs("R2");
    // R6: 0x1234 * -1
    rd_prod("R6");
    // R2: remaining parameters in their address order
    wr(16'h211D, 8'hCD, "R2"); wr(16'h211D, 8'hAB, "R2");
    wr(16'h211E, 8'h01, "R2"); wr(16'h211E, 8'h80, "R2");
    wr(16'h211F, 8'h55, "R2"); wr(16'h211F, 8'h00, "R2");
    wr(16'h2120, 8'h7F, "R2"); wr(16'h2120, 8'hFF, "R2");
    check_regs("R2");
    // R3: mode loads directly; next latched write still sees 0xFF
    wr(16'h211A, 8'h5A, "R3"); check_regs("R3");
    wr(16'h211D, 8'h11, "R3"); check_regs("R3");
    // R4: scroll offsets share the latch
    wr(16'h210D, 8'h22, "R4"); wr(16'h210D, 8'h03, "R4"); check_regs("R4");
    wr(16'h210E, 8'hEE, "R4"); check_regs("R4");
    // R5: operand is the raw byte (-128), not par_b
    wr(16'h211C, 8'h80, "R5"); check_regs("R5");
    rd_prod("R5");
    // R6: negative A times positive byte
    wr(16'h211B, 8'h00, "R6"); wr(16'h211B, 8'h80, "R6");
    wr(16'h211C, 8'h7F, "R6");
    rd_prod("R6");
    // R9: unmapped write changes nothing, latch included
    wr(16'h2121, 8'hA5, "R9"); check_regs("R9");
    wr(16'h211F, 8'h66, "R9"); check_regs("R9");
    // R8: non-product reads give no data
    rd(16'h2137, "R8"); rd(16'h2133, "R8"); rd(16'h211B, "R8");
    // R10: write B and read low byte together
    op(1'b1, 16'h211C, 8'hFD, 1'b1, 16'h2134, "R10");
    op(1'b1, 16'h211B, 8'h7B, 1'b1, 16'h2135, "R10");
    rd_prod("R10");
    // R11: reads leave the latch; next write's low byte is 0x7B
    rd_prod("R11"); rd(16'h2120, "R11");
    check_regs("R11");
    wr(16'h2120, 8'h09, "R11"); check_regs("R11");

    repeat (3) @(negedge clk);
    chk("R8", "pending reads", 16'(exp_q.size()), 16'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule